// File: doc/BRIEF.md
# Virtual Address Translation Lookup with Page Protection

This block turns a 32-bit virtual address into a physical address. It searches a small, fully associative table of translation entries, and each entry carries its own page size. Every entry holds a virtual page number, a physical page number, a size code, an address-space tag, valid, shared and dirty flags, and a two-bit protection code. A request carries the address, the access direction, the privilege level, the current address-space tag, a translation-enable bit and a single-address-space bit. One cycle later the block returns a registered result: the physical address, an OK flag and an exception code.

Two fixed address windows never use the table, and a privileged caller always reaches them with the top three address bits cleared. A user-mode caller may reach only a narrow queue window inside them. When translation is off, every other address is mapped the same way with full access. Each request that searches the table also advances a six-bit replacement pointer. The refill logic uses this pointer when it picks a victim slot. Entries are written one at a time through a simple write port, and a table write blocks any request in the same cycle.

Top module: `tlb_lookup`

## Requirements
- R1: `req_ready` is low in any cycle with `wr_en` high and high otherwise. A request is taken when `req_valid && req_ready`. `rsp_valid` is high in exactly the cycle after each accepted request, and only then.
- R2: An entry takes part in a match only when its valid flag is set. Tag checking is on only when `single_vm` is 0 and `req_priv` is 0. While it is on, the entry's tag must equal `cur_asid` or the entry must be marked shared.
- R3: Size code 0, 1, 2 or 3 gives a page of 1 KB, 4 KB, 64 KB or 1 MB. The entry matches when the address and `{vpn,10'b0}` agree above the in-page bits. The physical address is `{ppn,10'b0}` with its in-page bits cleared, ORed with the in-page bits of the address.
- R4: Two or more matching entries give exception code 0x140 with `rsp_ok` low.
- R5: No matching entry gives code 0x040 for a read and 0x060 for a write.
- R6: Protection is looked up by `{prot[1:0], req_priv}`. Values 000 and 010 deny every access: 0x0A0 for a read, 0x0C0 for a write. Values 001, 100 and 101 allow reads, and a write gets 0x0C0. Values 011, 110 and 111 allow both.
- R7: A write that protection allows, to an entry whose dirty flag is 0, gives code 0x080.
- R8: Addresses 0x80000000 to 0xBFFFFFFF, and 0xE0000000 and above, skip the table. With `req_priv` high they return OK with physical address `addr & 0x1FFFFFFF`.
- R9: With `req_priv` low, an address in those windows is allowed only from 0xE0000000 to 0xE4000000 inclusive. Any other address there gets the miss code of R5. This check applies even with translation off.
- R10: With `xlate_en` low, an address outside those windows returns OK with `addr & 0x1FFFFFFF` for reads and writes alike.
- R11: `repl_count` goes up by one on each accepted request that searches the table, which means `xlate_en` is high and the address is outside the windows. After an increment, the count becomes 0 if it equals `repl_bound` or equals 63.
- R12: `rsp_exc` is 0 when `rsp_ok` is high. `fault_addr` loads the request address of each faulting response and holds it until the next fault.
- R13: After reset all entries are invalid, and `rsp_valid`, `repl_count` and `fault_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write one table entry this cycle |
| wr_idx | input | 6 | Slot to write |
| wr_vpn | input | 22 | Virtual page number, 1 KB units |
| wr_ppn | input | 22 | Physical page number, 1 KB units |
| wr_size | input | 2 | Page size code |
| wr_asid | input | 8 | Address-space tag |
| wr_valid | input | 1 | Entry valid flag |
| wr_shared | input | 1 | Entry ignores the tag |
| wr_dirty | input | 1 | Page already written |
| wr_prot | input | 2 | Protection code |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | Privileged mode |
| cur_asid | input | 8 | Current address-space tag |
| xlate_en | input | 1 | Translation enabled |
| single_vm | input | 1 | Single address space, tag check off |
| repl_bound | input | 6 | Replacement pointer wrap boundary |
| rsp_valid | output | 1 | Result present |
| rsp_ok | output | 1 | Access allowed |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_exc | output | 12 | Exception code, 0 when OK |
| fault_addr | output | 32 | Address of the last fault |
| repl_count | output | 6 | Replacement pointer |

## Verification
A bad table slot or a wrong hit vector shows up one cycle after the request. It appears as a wrong physical address, an unexpected miss, or a false multiple-hit code. The bench therefore probes each page size on both sides of its boundary, and it also places two entries that overlap. A wrong replacement pointer is visible on `repl_count` right after the request that moved it. A stepping error is caught at once because the bench keeps its own count across a full wrap. A stale fault address would surface on the next faulting response, and every response compares `fault_addr`.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int VA_W   = 32;
  localparam int PN_W   = 22;
  localparam int ASID_W = 8;

  typedef struct packed {
    logic              valid;
    logic              shared;
    logic              dirty;
    logic [1:0]        prot;
    logic [1:0]        size;
    logic [ASID_W-1:0] asid;
    logic [PN_W-1:0]   vpn;
    logic [PN_W-1:0]   ppn;
  } tlb_entry_t;

  typedef enum logic [1:0] {ACC_NONE, ACC_RO, ACC_RW} acc_t;

  typedef enum logic [2:0] {
    F_NONE, F_MISS_RD, F_MISS_WR, F_INIT_WR, F_VIOL_RD, F_VIOL_WR, F_MULTI
  } fault_t;

  // in-page offset bits for a size code
  function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_03FF;
      2'd1:    return 32'h0000_0FFF;
      2'd2:    return 32'h0000_FFFF;
      default: return 32'h000F_FFFF;
    endcase
  endfunction

  // permission class from {prot, privileged}
  function automatic acc_t access_class(input logic [1:0] prot, input logic md);
    case ({prot, md})
      3'b000, 3'b010:         return ACC_NONE;
      3'b001, 3'b100, 3'b101: return ACC_RO;
      default:                return ACC_RW;
    endcase
  endfunction

  function automatic logic [11:0] exc_code(input fault_t f);
    case (f)
      F_MISS_RD: return 12'h040;
      F_MISS_WR: return 12'h060;
      F_INIT_WR: return 12'h080;
      F_VIOL_RD: return 12'h0A0;
      F_VIOL_WR: return 12'h0C0;
      F_MULTI:   return 12'h140;
      default:   return 12'h000;
    endcase
  endfunction

endpackage

// File: rtl/tlb_match_cell.sv
module tlb_match_cell
  import tlb_pkg::*;
(
  input  logic              valid,
  input  logic              shared,
  input  logic [1:0]        size,
  input  logic [ASID_W-1:0] asid,
  input  logic [PN_W-1:0]   vpn,
  input  logic [VA_W-1:0]   vaddr,
  input  logic              use_asid,
  input  logic [ASID_W-1:0] cur_asid,
  output logic              hit
);
  logic [VA_W-1:0] mask;
  logic [VA_W-1:0] base;
  logic            tag_ok;

  assign mask   = page_mask(size);
  assign base   = {vpn, 10'b0} & ~mask;
  assign tag_ok = !use_asid || shared || (asid == cur_asid);
  assign hit    = valid && tag_ok && ((vaddr & ~mask) == base);
endmodule

// File: rtl/tlb_repl_ctr.sv
module tlb_repl_ctr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] bound,
  output logic [W-1:0] count
);
  logic [W-1:0] bumped;

  assign bumped = count + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (step)
      count <= (bumped == bound || bumped == '1) ? '0 : bumped;
  end

  AST_REPL_NEVER_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    count != '1); // R11
  AST_REPL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (count == $past(count) + W'(1)) || (count == '0)); // R11
  AST_REPL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(count)); // R11
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PN_W-1:0]   wr_vpn,
  input  logic [PN_W-1:0]   wr_ppn,
  input  logic [1:0]        wr_size,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_valid,
  input  logic              wr_shared,
  input  logic              wr_dirty,
  input  logic [1:0]        wr_prot,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_addr,
  input  logic              req_write,
  input  logic              req_priv,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              xlate_en,
  input  logic              single_vm,
  input  logic [IDX_W-1:0]  repl_bound,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic [11:0]       rsp_exc,
  output logic [VA_W-1:0]   fault_addr,
  output logic [IDX_W-1:0]  repl_count
);
  tlb_entry_t      tbl [ENTRIES];
  tlb_entry_t      wr_entry;
  tlb_entry_t      sel;
  logic [ENTRIES-1:0] hit_vec;
  logic            hit_any, hit_multi;
  logic            use_asid, in_bypass, sq_window, tlb_search;
  logic            req_fire, lookup_fire;
  fault_t          fault;
  acc_t            acc;
  logic [VA_W-1:0] sel_mask, pa;

  // ---------------- table storage ----------------
  assign wr_entry = '{valid: wr_valid, shared: wr_shared, dirty: wr_dirty,
                      prot: wr_prot, size: wr_size, asid: wr_asid,
                      vpn: wr_vpn, ppn: wr_ppn};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_entry;
    end
  end

  // ---------------- request side ----------------
  assign req_ready   = !wr_en;
  assign req_fire    = req_valid && req_ready;
  assign use_asid    = !single_vm && !req_priv;
  assign in_bypass   = (req_addr[31:30] == 2'b10) || (req_addr[31:29] == 3'b111);
  assign sq_window   = (req_addr >= 32'hE000_0000) && (req_addr <= 32'hE400_0000);
  assign tlb_search  = xlate_en && !in_bypass;
  assign lookup_fire = req_fire && tlb_search;

  // ---------------- parallel compare ----------------
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
    tlb_match_cell u_cell (
      .valid    (tbl[g].valid),
      .shared   (tbl[g].shared),
      .size     (tbl[g].size),
      .asid     (tbl[g].asid),
      .vpn      (tbl[g].vpn),
      .vaddr    (req_addr),
      .use_asid (use_asid),
      .cur_asid (cur_asid),
      .hit      (hit_vec[g])
    );
  end

  always_comb begin
    hit_any   = 1'b0;
    hit_multi = 1'b0;
    sel       = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        if (hit_any) hit_multi = 1'b1;
        hit_any = 1'b1;
        sel     = tbl[i];
      end
    end
  end

  // ---------------- decision ----------------
  assign acc      = access_class(sel.prot, req_priv);
  assign sel_mask = page_mask(sel.size);

  always_comb begin
    fault = F_NONE;
    pa    = {3'b000, req_addr[28:0]};
    if (in_bypass) begin
      if (!req_priv && !sq_window)
        fault = req_write ? F_MISS_WR : F_MISS_RD;
    end else if (xlate_en) begin
      pa = ({sel.ppn, 10'b0} & ~sel_mask) | (req_addr & sel_mask);
      if (hit_multi)                         fault = F_MULTI;
      else if (!hit_any)                     fault = req_write ? F_MISS_WR : F_MISS_RD;
      else if (acc == ACC_NONE)              fault = req_write ? F_VIOL_WR : F_VIOL_RD;
      else if (acc == ACC_RO && req_write)   fault = F_VIOL_WR;
      else if (req_write && !sel.dirty)      fault = F_INIT_WR;
    end
  end

  // ---------------- registered result ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_ok     <= 1'b0;
      rsp_paddr  <= '0;
      rsp_exc    <= '0;
      fault_addr <= '0;
    end else begin
      rsp_valid <= req_fire;
      if (req_fire) begin
        rsp_ok    <= (fault == F_NONE);
        rsp_paddr <= (fault == F_NONE) ? pa : '0;
        rsp_exc   <= exc_code(fault);
        if (fault != F_NONE) fault_addr <= req_addr;
      end
    end
  end

  tlb_repl_ctr #(.W(IDX_W)) u_repl (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (lookup_fire),
    .bound (repl_bound),
    .count (repl_count)
  );

  // ---------------- assertions ----------------
  AST_HOLD_OFF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !req_ready); // R1
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> rsp_valid); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_fire |=> !rsp_valid); // R1
  AST_MULTI_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_fire && hit_multi) |=> (!rsp_ok && rsp_exc == 12'h140)); // R4
  AST_BYPASS_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && in_bypass && req_priv) |=>
      (rsp_ok && rsp_paddr == {3'b000, $past(req_addr[28:0])})); // R8
  AST_XLATE_OFF_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !xlate_en && !in_bypass) |=> rsp_ok); // R10
  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> (rsp_ok || fault_addr == $past(req_addr))); // R12
endmodule

// File: tb/tlb_lookup_test.sv
module tlb_lookup_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [21:0] wr_vpn = '0, wr_ppn = '0;
  logic [1:0]  wr_size = '0, wr_prot = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_valid = 1'b0, wr_shared = 1'b0, wr_dirty = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [7:0]  cur_asid = 8'd5;
  logic        xlate_en = 1'b1, single_vm = 1'b0;
  logic [5:0]  repl_bound = 6'd0;
  logic        rsp_valid, rsp_ok;
  logic [31:0] rsp_paddr, fault_addr;
  logic [11:0] rsp_exc;
  logic [5:0]  repl_count;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [5:0]  model_cnt = '0;
  logic [31:0] model_fa = '0;

  logic        q_ok  [$];
  logic [11:0] q_exc [$];
  logic [31:0] q_pa  [$];
  logic [5:0]  q_cnt [$];
  logic [31:0] q_fa  [$];
  string       q_tag [$];

  always #2 clk = ~clk;

  tlb_lookup uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
    .wr_ppn(wr_ppn), .wr_size(wr_size), .wr_asid(wr_asid), .wr_valid(wr_valid),
    .wr_shared(wr_shared), .wr_dirty(wr_dirty), .wr_prot(wr_prot),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_priv(req_priv), .cur_asid(cur_asid),
    .xlate_en(xlate_en), .single_vm(single_vm), .repl_bound(repl_bound),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_paddr(rsp_paddr),
    .rsp_exc(rsp_exc), .fault_addr(fault_addr), .repl_count(repl_count)
  );

  task automatic chk(input bit good, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [5:0] idx, input logic [31:0] va, input logic [31:0] pa_base,
                     input logic [1:0] sz, input logic [7:0] tag, input bit v,
                     input bit sh, input bit d, input logic [1:0] pr);
    @(negedge clk);
    req_valid = 1'b0;
    wr_en = 1'b1; wr_idx = idx; wr_vpn = va[31:10]; wr_ppn = pa_base[31:10];
    wr_size = sz; wr_asid = tag; wr_valid = v; wr_shared = sh; wr_dirty = d; wr_prot = pr;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // window test restated from the requirement text
  function automatic bit skips_table(input logic [31:0] a);
    return (a >= 32'h8000_0000 && a <= 32'hBFFF_FFFF) || (a >= 32'hE000_0000);
  endfunction

  task automatic look(input logic [31:0] a, input bit w, input bit md, input bit eok,
                      input logic [11:0] eexc, input logic [31:0] epa, input string tag);
    logic [5:0] nx;
    @(negedge clk);
    wr_en = 1'b0;
    req_valid = 1'b1; req_addr = a; req_write = w; req_priv = md;
    if (xlate_en && !skips_table(a)) begin
      nx = model_cnt + 6'd1;
      model_cnt = (nx == repl_bound || nx == 6'd63) ? 6'd0 : nx;
    end
    if (!eok) model_fa = a;
    q_ok.push_back(eok); q_exc.push_back(eexc); q_pa.push_back(epa);
    q_cnt.push_back(model_cnt); q_fa.push_back(model_fa); q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0; wr_en = 1'b0;
    end
  endtask

  // monitor: compare each response against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_ok.size() == 0) begin
        chk(1'b0, "R1 unexpected response", {31'b0, rsp_valid}, 32'h0);
      end else begin
        logic e_ok; logic [11:0] e_exc; logic [31:0] e_pa, e_fa; logic [5:0] e_cnt; string t;
        bit good;
        e_ok = q_ok.pop_front(); e_exc = q_exc.pop_front(); e_pa = q_pa.pop_front();
        e_cnt = q_cnt.pop_front(); e_fa = q_fa.pop_front(); t = q_tag.pop_front();
        good = (rsp_ok == e_ok) && (rsp_exc == e_exc) && (!e_ok || rsp_paddr == e_pa) &&
               (repl_count == e_cnt) && (fault_addr == e_fa);
        n_chk++;
        if (!good) begin
          n_bad++;
          $display("FAIL %s: actual ok=%0b exc=%h pa=%h cnt=%0d fa=%h expected ok=%0b exc=%h pa=%h cnt=%0d fa=%h",
                   t, rsp_ok, rsp_exc, rsp_paddr, repl_count, fault_addr,
                   e_ok, e_exc, e_pa, e_cnt, e_fa);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(rsp_valid == 1'b0, "R13 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk(repl_count == 6'd0, "R13 repl_count", {26'b0, repl_count}, 32'h0);
    chk(fault_addr == 32'h0, "R13 fault_addr", fault_addr, 32'h0);
    chk(req_ready == 1'b1, "R1 ready idle", {31'b0, req_ready}, 32'h1);
    look(32'h0001_0ABC, 0, 0, 0, 12'h040, 0, "R13 empty table misses");
    idle(2);

    put(6'd0,  32'h0001_0000, 32'h0020_0000, 2'd1, 8'd5, 1, 0, 1, 2'd3);
    put(6'd1,  32'h0002_0400, 32'h0030_0000, 2'd0, 8'd5, 1, 0, 1, 2'd0);
    put(6'd2,  32'h0010_0000, 32'h0123_0000, 2'd2, 8'd9, 1, 1, 1, 2'd2);
    put(6'd3,  32'h0040_5400, 32'h00A0_1400, 2'd3, 8'd5, 1, 0, 0, 2'd3);
    put(6'd4,  32'h0080_0000, 32'h0100_0000, 2'd1, 8'd5, 1, 0, 1, 2'd3);
    put(6'd5,  32'h0080_0000, 32'h0200_0000, 2'd1, 8'd5, 1, 0, 1, 2'd3);
    put(6'd6,  32'h0090_0000, 32'h0300_0000, 2'd1, 8'd5, 0, 0, 1, 2'd3);
    put(6'd7,  32'h00A0_0000, 32'h00B0_0000, 2'd1, 8'd7, 1, 0, 1, 2'd3);
    put(6'd63, 32'h00C0_0000, 32'h00D0_0000, 2'd1, 8'd5, 1, 0, 1, 2'd1);

    // R3 page sizes and address composition; R6 protection table
    look(32'h0001_0ABC, 0, 0, 1, 12'h000, 32'h0020_0ABC, "R3 4K read");
    look(32'h0001_0ABC, 1, 0, 1, 12'h000, 32'h0020_0ABC, "R6 rw user write");
    look(32'h0002_0455, 0, 0, 0, 12'h0A0, 0, "R6 000 read denied");
    look(32'h0002_0455, 1, 0, 0, 12'h0C0, 0, "R6 000 write denied");
    look(32'h0002_0455, 0, 1, 1, 12'h000, 32'h0030_0055, "R3 1K priv read 001");
    look(32'h0002_0455, 1, 1, 0, 12'h0C0, 0, "R6 001 write");
    look(32'h0002_0800, 0, 1, 0, 12'h040, 0, "R3 1K upper edge");
    look(32'h0002_03FF, 0, 1, 0, 12'h040, 0, "R3 1K lower edge");
    look(32'h0010_ABCD, 0, 0, 1, 12'h000, 32'h0123_ABCD, "R2 shared 64K read");
    look(32'h0010_FFFF, 0, 0, 1, 12'h000, 32'h0123_FFFF, "R3 64K last byte");
    look(32'h0011_0000, 0, 0, 0, 12'h040, 0, "R3 64K past end");
    look(32'h0010_ABCD, 1, 0, 0, 12'h0C0, 0, "R6 100 write");
    look(32'h0010_ABCD, 1, 1, 0, 12'h0C0, 0, "R6 101 write");
    look(32'h0045_6789, 0, 0, 1, 12'h000, 32'h00A5_6789, "R3 1M masked bases");
    look(32'h0045_6789, 1, 0, 0, 12'h080, 0, "R7 clean page write");
    look(32'h0080_0010, 0, 0, 0, 12'h140, 0, "R4 two hits");
    look(32'h0090_0000, 0, 0, 0, 12'h040, 0, "R2 invalid entry");
    look(32'h0090_0000, 1, 0, 0, 12'h060, 0, "R5 write miss");
    look(32'h00A0_0123, 0, 0, 0, 12'h040, 0, "R2 foreign tag");
    look(32'h00A0_0123, 0, 1, 1, 12'h000, 32'h00B0_0123, "R2 priv skips tag");
    idle(1);
    single_vm = 1'b1;
    look(32'h00A0_0123, 0, 0, 1, 12'h000, 32'h00B0_0123, "R2 single space skips tag");
    idle(1);
    single_vm = 1'b0;
    look(32'h00C0_0010, 0, 0, 0, 12'h0A0, 0, "R6 010 read");
    look(32'h00C0_0010, 1, 1, 1, 12'h000, 32'h00D0_0010, "R6 011 write");

    // R8 / R9 windows
    look(32'h8123_4567, 0, 1, 1, 12'h000, 32'h0123_4567, "R8 low window");
    look(32'hA000_0004, 1, 1, 1, 12'h000, 32'h0000_0004, "R8 uncached window");
    look(32'hFFFF_FFF0, 0, 1, 1, 12'h000, 32'h1FFF_FFF0, "R8 top window");
    look(32'h9000_0000, 0, 0, 0, 12'h040, 0, "R9 user read blocked");
    look(32'h8000_0000, 1, 0, 0, 12'h060, 0, "R9 user write blocked");
    look(32'hE000_0000, 0, 0, 1, 12'h000, 32'h0000_0000, "R9 queue window start");
    look(32'hE400_0000, 1, 0, 1, 12'h000, 32'h0400_0000, "R9 queue window end");
    look(32'hE400_0004, 0, 0, 0, 12'h040, 0, "R9 past queue window");
    look(32'hDFFF_FFFF, 0, 0, 0, 12'h040, 0, "R11 translated region counts");

    // R10 translation off
    idle(1);
    xlate_en = 1'b0;
    look(32'h0045_6789, 1, 0, 1, 12'h000, 32'h0045_6789, "R10 clean write passes");
    look(32'h7FFF_FFFF, 0, 0, 1, 12'h000, 32'h1FFF_FFFF, "R10 mask");
    look(32'hC000_1234, 0, 0, 1, 12'h000, 32'h0000_1234, "R10 region above");
    look(32'h8000_0000, 0, 0, 0, 12'h040, 0, "R9 window check with xlate off");
    idle(1);
    xlate_en = 1'b1;

    // R1 table write blocks a request
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0001_0ABC; req_write = 1'b0; req_priv = 1'b0;
    wr_en = 1'b1; wr_idx = 6'd0; wr_vpn = 22'h40; wr_ppn = 22'h800; wr_size = 2'd1;
    wr_asid = 8'd5; wr_valid = 1'b1; wr_shared = 1'b0; wr_dirty = 1'b1; wr_prot = 2'd3;
    #1 chk(req_ready == 1'b0, "R1 ready low on write", {31'b0, req_ready}, 32'h0);
    idle(2);

    // R11 full wrap at 63, then a near boundary
    for (int k = 0; k < 70; k++)
      look(32'h00F0_0000, 0, 0, 0, 12'h040, 0, "R11 wrap at top");
    idle(1);
    repl_bound = model_cnt + 6'd3;
    for (int k = 0; k < 6; k++)
      look(32'h00F0_0004, 0, 1, 0, 12'h040, 0, "R11 bound wrap");
    // R12 fault address holds over an OK response
    look(32'h0001_0ABC, 0, 0, 1, 12'h000, 32'h0020_0ABC, "R12 fault address held");
    idle(4);
    chk(q_ok.size() == 0, "R1 all responses seen", q_ok.size(), 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule